// File: doc/BRIEF.md
# Multichannel Triggered Peak Capture

This block watches a set of synchronous converter channels that share one sample-valid strobe. Each channel is compared with its own threshold. The first valid sample in which any channel rises strictly above its threshold opens a capture window of fixed length, and the window covers every channel. Throughout the window the block keeps the largest value seen on each channel. When the window closes, the peaks of all channels form one event vector.

Event vectors are gathered into batches of a fixed size. A batch is released downstream only once it is complete. It leaves as a stream of single-channel words on a valid/ready interface and carries an end-of-batch marker. Two batch banks alternate, so one bank can fill while the other drains. An event that completes while both banks are occupied is discarded and counted.

The block suits particle or pulse counters in which short bursts arrive with long quiet gaps between them. Downstream logic, such as a packet framer, receives ready-made groups of peak vectors and never sees raw samples. Thresholds are static inputs that the surrounding logic supplies, one field per channel.

Top module: `peak_batch_capture`

## Requirements
- R1: A window opens only on a valid sample in which at least one channel's unsigned value is strictly greater than that channel's threshold. A sample equal to its threshold on every channel opens nothing.
- R2: A window spans exactly WIN valid samples, and the sample that opened it counts as the first. Each channel's stored peak is the maximum of that channel over those samples only. Peaks start from zero at window open.
- R3: Crossings inside an open window are ignored. After a window closes, the trigger rearms only after a valid sample in which every channel is at or below its threshold. Samples above threshold before that point start no event.
- R4: out_valid_o stays low until BATCH events have been stored in one bank. The bank is then sent as NCH*BATCH words. Events leave in the order they were stored. Within an event, channel 0 comes first, and channel c's peak sits at bits [c*SW +: SW] of smp_i/thr_i.
- R5: out_last_o is high on the final word of each batch and low on every other word.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o and out_last_o hold their values.
- R7: Two banks alternate. A second batch fills while the first waits or drains, and batches come out in the order they filled.
- R8: An event that completes while both banks hold undelivered batches is discarded and never appears at the output. ovf_cnt_o rises by one for each such event and saturates at its maximum value.
- R9: During and right after reset, out_valid_o is low and ovf_cnt_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Strobe shared by all channels; marks a new sample set |
| smp_i | input | NCH*SW | Unsigned sample of each channel, channel c at [c*SW +: SW] |
| thr_i | input | NCH*SW | Threshold of each channel, same packing as smp_i |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | SW | One channel peak |
| out_last_o | output | 1 | Final word of the batch |
| ovf_cnt_o | output | OVF_W | Saturating count of discarded events |

## Verification
The bench drives samples that sit exactly on the thresholds. A design that used greater-or-equal would capture a phantom event, and that event would show up as an extra vector at the head of the first batch. Every stimulus event places a larger value on the sample just after the window and keeps the channels above threshold there. A window that ran one sample too long would report that value as a peak. A trigger that rearmed without first seeing a quiet sample would store a second event that nobody sent. The bench also holds both banks full and pushes further events through. It expects the counter to step and then saturate, and it expects the discarded vectors to be absent from both drained batches. Stalls on the output check that words do not change and are not lost.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OPEN  = 2'd1,
      ST_STORE = 2'd2,
      ST_REARM = 2'd3
   } pbc_state_e;

   function automatic int unsigned pbc_idx_w(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/pbc_trigger.sv
module pbc_trigger
   import pbc_pkg::*;
#(
   parameter int unsigned NCH = 16,
   parameter int unsigned SW  = 12,
   parameter int unsigned WIN = 34
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              smp_valid_i,
   input  logic [NCH*SW-1:0] smp_i,
   input  logic [NCH*SW-1:0] thr_i,
   output logic              open_o,
   output logic              take_o,
   output logic              store_o
);
   localparam int unsigned CNT_W = $clog2(WIN + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN - 1);

   pbc_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NCH-1:0]   above;
   logic             any_above;

   for (genvar c = 0; c < NCH; c++) begin : g_cmp
      assign above[c] = smp_i[c*SW +: SW] > thr_i[c*SW +: SW];
   end
   assign any_above = |above;

   assign open_o  = (st_q == ST_IDLE) && smp_valid_i && any_above;
   assign take_o  = open_o || ((st_q == ST_OPEN) && smp_valid_i);
   assign store_o = (st_q == ST_STORE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (open_o) begin
                  cnt_q <= CNT_W'(1);
                  st_q  <= (WIN == 1) ? ST_STORE : ST_OPEN;
               end
            end
            ST_OPEN: begin
               if (smp_valid_i) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_CNT) st_q <= ST_STORE;
               end
            end
            ST_STORE: st_q <= ST_REARM;
            ST_REARM: begin
               if (smp_valid_i && !any_above) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pbc_peak_track.sv
module pbc_peak_track #(
   parameter int unsigned NCH = 16,
   parameter int unsigned SW  = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              open_i,
   input  logic              take_i,
   input  logic [NCH*SW-1:0] smp_i,
   output logic [NCH*SW-1:0] peaks_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SW-1:0] pk_q;
      logic [SW-1:0] s;
      assign s = smp_i[c*SW +: SW];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pk_q <= '0;
         end else if (open_i) begin
            pk_q <= s;
         end else if (take_i && (s > pk_q)) begin
            pk_q <= s;
         end
      end
      assign peaks_o[c*SW +: SW] = pk_q;
   end
endmodule

// File: rtl/pbc_batch_buf.sv
module pbc_batch_buf
   import pbc_pkg::*;
#(
   parameter int unsigned NCH   = 16,
   parameter int unsigned SW    = 12,
   parameter int unsigned BATCH = 100,
   parameter int unsigned OVF_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              store_i,
   input  logic [NCH*SW-1:0] row_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [SW-1:0]     out_data_o,
   output logic              out_last_o,
   output logic [OVF_W-1:0]  ovf_cnt_o
);
   localparam int unsigned RW    = NCH * SW;
   localparam int unsigned IW    = pbc_idx_w(BATCH);
   localparam int unsigned CW    = pbc_idx_w(NCH);
   localparam int unsigned DEPTH = 2 * BATCH;
   localparam logic [IW-1:0] LAST_ROW = IW'(BATCH - 1);
   localparam logic [CW-1:0] LAST_CH  = CW'(NCH - 1);

   logic [RW-1:0]    mem [DEPTH];
   logic [1:0]       full_q, full_d;
   logic             wbank_q, rbank_q;
   logic [IW-1:0]    widx_q, ridx_q;
   logic [CW-1:0]    rch_q;
   logic [OVF_W-1:0] ovf_q;
   logic             wr_en, drop, beat, row_end, batch_end, wr_fill;
   logic [RW-1:0]    rd_row;

   assign drop      = store_i && full_q[wbank_q];
   assign wr_en     = store_i && !full_q[wbank_q];
   assign wr_fill   = wr_en && (widx_q == LAST_ROW);
   assign beat      = out_valid_o && out_ready_i;
   assign row_end   = (rch_q == LAST_CH);
   assign batch_end = row_end && (ridx_q == LAST_ROW);

   always_ff @(posedge clk_i) begin
      if (wr_en) mem[int'(wbank_q) * BATCH + int'(widx_q)] <= row_i;
   end

   assign rd_row = mem[int'(rbank_q) * BATCH + int'(ridx_q)];

   if (NCH == 1) begin : g_sel_single
      assign out_data_o = rd_row[SW-1:0];
   end else begin : g_sel_multi
      assign out_data_o = rd_row[int'(rch_q)*SW +: SW];
   end

   assign out_valid_o = full_q[rbank_q];
   assign out_last_o  = out_valid_o && batch_end;
   assign ovf_cnt_o   = ovf_q;

   always_comb begin
      full_d = full_q;
      if (beat && batch_end) full_d[rbank_q] = 1'b0;
      if (wr_fill)           full_d[wbank_q] = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q  <= '0;
         wbank_q <= 1'b0;
         widx_q  <= '0;
      end else begin
         full_q <= full_d;
         if (wr_en) begin
            if (wr_fill) begin
               widx_q  <= '0;
               wbank_q <= ~wbank_q;
            end else begin
               widx_q <= widx_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rbank_q <= 1'b0;
         ridx_q  <= '0;
         rch_q   <= '0;
      end else if (beat) begin
         if (row_end) begin
            rch_q <= '0;
            if (batch_end) begin
               ridx_q  <= '0;
               rbank_q <= ~rbank_q;
            end else begin
               ridx_q <= ridx_q + 1'b1;
            end
         end else begin
            rch_q <= rch_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q <= '0;
      end else if (drop && (ovf_q != {OVF_W{1'b1}})) begin
         ovf_q <= ovf_q + 1'b1;
      end
   end
endmodule

// File: rtl/peak_batch_capture.sv
module peak_batch_capture #(
   parameter int unsigned NCH   = 16,
   parameter int unsigned SW    = 12,
   parameter int unsigned WIN   = 34,
   parameter int unsigned BATCH = 100,
   parameter int unsigned OVF_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              smp_valid_i,
   input  logic [NCH*SW-1:0] smp_i,
   input  logic [NCH*SW-1:0] thr_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [SW-1:0]     out_data_o,
   output logic              out_last_o,
   output logic [OVF_W-1:0]  ovf_cnt_o
);
   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("peak_batch_capture: NCH must lie in 1..32");
   end
   if (SW < 2 || SW > 16) begin : g_bad_sw
      $error("peak_batch_capture: SW must lie in 2..16");
   end
   if (WIN < 1) begin : g_bad_win
      $error("peak_batch_capture: WIN must be at least 1");
   end
   if (BATCH < 1) begin : g_bad_batch
      $error("peak_batch_capture: BATCH must be at least 1");
   end
   if (OVF_W < 1) begin : g_bad_ovf
      $error("peak_batch_capture: OVF_W must be at least 1");
   end

   logic              open_w, take_w, store_w;
   logic [NCH*SW-1:0] peaks_w;

   pbc_trigger #(.NCH(NCH), .SW(SW), .WIN(WIN)) u_trig (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .smp_valid_i (smp_valid_i),
      .smp_i       (smp_i),
      .thr_i       (thr_i),
      .open_o      (open_w),
      .take_o      (take_w),
      .store_o     (store_w)
   );

   pbc_peak_track #(.NCH(NCH), .SW(SW)) u_peak (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .open_i  (open_w),
      .take_i  (take_w),
      .smp_i   (smp_i),
      .peaks_o (peaks_w)
   );

   pbc_batch_buf #(.NCH(NCH), .SW(SW), .BATCH(BATCH), .OVF_W(OVF_W)) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .store_i     (store_w),
      .row_i       (peaks_w),
      .out_valid_o (out_valid_o),
      .out_ready_i (out_ready_i),
      .out_data_o  (out_data_o),
      .out_last_o  (out_last_o),
      .ovf_cnt_o   (ovf_cnt_o)
   );
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
   parameter int unsigned NCH   = 16,
   parameter int unsigned SW    = 12,
   parameter int unsigned BATCH = 100,
   parameter int unsigned OVF_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             out_valid_o,
   input logic             out_ready_i,
   input logic [SW-1:0]    out_data_o,
   input logic             out_last_o,
   input logic [OVF_W-1:0] ovf_cnt_o
);
   localparam int unsigned TOT = NCH * BATCH;
   int unsigned beat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) beat_q <= 0;
      else if (out_valid_o && out_ready_i) beat_q <= (beat_q == TOT - 1) ? 0 : beat_q + 1;
   end

   AST_RST_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!out_valid_o && ovf_cnt_o == '0)); // R9
   AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o))); // R6
   AST_LAST_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (out_last_o == (beat_q == TOT - 1))); // R5
   AST_OVF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ovf_cnt_o) |-> (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1)); // R8
   AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_cnt_o == {OVF_W{1'b1}}) |=> (ovf_cnt_o == {OVF_W{1'b1}})); // R8
endmodule

bind peak_batch_capture pbc_checker #(
   .NCH(NCH), .SW(SW), .BATCH(BATCH), .OVF_W(OVF_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_data_o  (out_data_o),
   .out_last_o  (out_last_o),
   .ovf_cnt_o   (ovf_cnt_o)
);

// File: tb/peak_batch_capture_tb_top.sv
`timescale 1ns/1ps
module peak_batch_capture_tb_top;
   localparam int NCH = 4, SW = 12, WIN = 4, BATCH = 2, OVF_W = 2;
   localparam int RW = NCH * SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [RW-1:0] smp = '0;
   logic [RW-1:0] thr;
   logic          out_valid, out_ready = 1'b0, out_last;
   logic [SW-1:0] out_data;
   logic [OVF_W-1:0] ovf_cnt;

   int n_tests = 0, n_fail = 0;
   logic [RW-1:0] expq[$];

   always #10 clk = ~clk;

   peak_batch_capture #(.NCH(NCH), .SW(SW), .WIN(WIN), .BATCH(BATCH), .OVF_W(OVF_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_i(smp), .thr_i(thr),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
      .out_last_o(out_last), .ovf_cnt_o(ovf_cnt));

   assign thr = {12'd400, 12'd300, 12'd200, 12'd100};

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [RW-1:0] v);
      @(negedge clk); smp = v; smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0; smp = '0;
      repeat (2) @(negedge clk);
   endtask

   // One event: trigger sample, WIN-1 in-window samples (one above threshold, R3),
   // a larger post-window sample still above threshold (R2/R3), then a quiet sample.
   task automatic send_event(input int seed, input bit expect_kept);
      logic [RW-1:0] v, mx;
      int t;
      mx = '0;
      t = seed % NCH;
      v = '0;
      v[t*SW +: SW] = thr[t*SW +: SW] + 12'd1;
      mx = v;
      push(v);
      for (int k = 1; k < WIN; k++) begin
         for (int c = 0; c < NCH; c++) begin
            if (k == 1) v[c*SW +: SW] = thr[c*SW +: SW] + SW'(2 + seed);
            else        v[c*SW +: SW] = SW'((seed * 37 + k * 53 + c * 101) % 3000);
            if (v[c*SW +: SW] > mx[c*SW +: SW]) mx[c*SW +: SW] = v[c*SW +: SW];
         end
         push(v);
      end
      push({NCH{12'd4000}});
      push('0);
      if (expect_kept) expq.push_back(mx);
   endtask

   task automatic drain_batch(input bit stall);
      logic [RW-1:0] row;
      for (int e = 0; e < BATCH; e++) begin
         row = (expq.size() > 0) ? expq.pop_front() : '0;
         for (int c = 0; c < NCH; c++) begin
            int w;
            logic [SW-1:0] held;
            w = 0;
            while (!out_valid && w < 100) begin @(negedge clk); w++; end
            check(out_valid, "R4", "valid during drain", int'(out_valid), 1);
            check(out_data == row[c*SW +: SW], "R4", $sformatf("peak ev%0d ch%0d", e, c),
                  int'(out_data), int'(row[c*SW +: SW]));
            check(out_last == (e == BATCH-1 && c == NCH-1), "R5", "last flag",
                  int'(out_last), int'(e == BATCH-1 && c == NCH-1));
            if (stall) begin
               held = out_data;
               @(negedge clk);
               check(out_valid && out_data == held, "R6", "hold under stall", int'(out_data), int'(held));
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
         end
      end
   endtask

   task automatic t_reset;
      check(!out_valid, "R9", "valid in reset", int'(out_valid), 0);
      check(ovf_cnt == 0, "R9", "ovf in reset", int'(ovf_cnt), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!out_valid && ovf_cnt == 0, "R9", "idle after reset", int'(out_valid), 0);
   endtask

   // R1: equal-to-threshold gives no event; R2/R3/R4/R5/R6 via the first batch.
   task automatic t_threshold_and_batch;
      push(thr);
      push(thr);
      send_event(1, 1'b1);
      repeat (3) @(negedge clk);
      check(!out_valid, "R4", "held until batch full", int'(out_valid), 0);
      send_event(6, 1'b1);
      repeat (3) @(negedge clk);
      check(out_valid, "R1", "batch of sent events only", int'(out_valid), 1);
      drain_batch(1'b1);
      repeat (2) @(negedge clk);
      check(!out_valid, "R4", "empty after drain", int'(out_valid), 0);
   endtask

   // R7/R8: fill both banks, overflow, saturate, then drain in fill order.
   task automatic t_pingpong_overflow;
      send_event(2, 1'b1);
      send_event(3, 1'b1);
      send_event(4, 1'b1);
      send_event(5, 1'b1);
      repeat (3) @(negedge clk);
      check(ovf_cnt == 0, "R7", "second bank absorbs batch", int'(ovf_cnt), 0);
      send_event(9, 1'b0);
      repeat (3) @(negedge clk);
      check(ovf_cnt == 1, "R8", "first drop counted", int'(ovf_cnt), 1);
      send_event(10, 1'b0);
      send_event(11, 1'b0);
      repeat (3) @(negedge clk);
      check(ovf_cnt == 3, "R8", "drops counted", int'(ovf_cnt), 3);
      send_event(12, 1'b0);
      repeat (3) @(negedge clk);
      check(ovf_cnt == 3, "R8", "counter saturates", int'(ovf_cnt), 3);
      drain_batch(1'b1);
      drain_batch(1'b0);
      repeat (2) @(negedge clk);
      check(!out_valid, "R7", "both banks emptied", int'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_threshold_and_batch();
      t_pingpong_overflow();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule